// File: doc/BRIEF.md
# Step-Table Output Sequencer

The block steps through a table of rows. Each row holds an 8-bit output pattern and its own preset. The output word always shows the pattern of the row the sequencer is on. One accumulator counts progress inside the current row. In event mode it counts rising edges of a condition input. In time mode it counts 0.1 s ticks, and only while the condition is high. When the count reaches the row's preset, the accumulator clears and the sequencer moves to the next row. After a configurable last row it returns to row 0.

Rows are loaded through a simple write port. A restart input sends the sequencer back to row 0 at any time. The 0.1 s tick comes from a free-running divider of the clock, set by a parameter. Typical uses are machine drums and fixed actuation sequences, where each step either waits for a number of sensor events or dwells for a set time.

Top module: `drum_seq`

## Requirements
- R1: `out_o` equals the pattern stored for the row in `step_o`. It changes in the same clock cycle as `step_o`.
- R2: In event mode (`mode_i`=0), `acc_o` increases by one on each clock edge where `cond_i` is high and was low at the previous edge. Holding `cond_i` high or low leaves `acc_o` and `step_o` unchanged.
- R3: In time mode (`mode_i`=1), `acc_o` increases by one on each tick while `cond_i` is high. A tick comes once every `TICK_DIV` clock cycles. While `cond_i` is low, `acc_o` and `step_o` hold.
- R4: When an increment would make `acc_o` equal to the row's preset, `acc_o` becomes 0 and `step_o` advances on that same edge.
- R5: A row whose preset is 0 behaves as if its preset were 1: one increment advances it.
- R6: Advancing from a row at or beyond `last_step_i` goes to row 0. A `last_step_i` of `MAX_STEPS` or more acts as `MAX_STEPS-1` (99 by default). `step_o` never reaches `MAX_STEPS`.
- R7: A clock edge with `seq_rst_i` high sets `step_o` and `acc_o` to 0. This overrides any increment on the same edge.
- R8: While `rst_ni` is low, `step_o` and `acc_o` are 0 and every table row holds pattern 0 and preset 0.
- R9: A clock edge with `wr_en_i` high stores `wr_pattern_i` and `wr_preset_i` in row `wr_addr_i`. A write to an address of `MAX_STEPS` or more changes no row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = event counting, 1 = timed dwell |
| cond_i | input | 1 | Condition input |
| seq_rst_i | input | 1 | Synchronous restart to row 0 |
| last_step_i | input | 7 | Index of the last row before the sequence wraps |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | 7 | Table row to write |
| wr_pattern_i | input | 8 | Output pattern to store |
| wr_preset_i | input | 8 | Event count or dwell tick count to store |
| step_o | output | 7 | Current row index |
| acc_o | output | 8 | Accumulator value |
| out_o | output | 8 | Output pattern of the current row |

## Verification
The assertions assume that every input changes synchronously with `clk_i`, and that `mode_i` changes only while the condition is idle. Under that assumption, the rising edge seen by the counter is the edge the properties reason about. The assertions also assume that the row being counted is not rewritten with a lower preset partway through its count. The bench follows these assumptions. It drives every input on the falling clock edge and changes `mode_i` only with `cond_i` low. It loads or rewrites table rows only while the sequencer is parked elsewhere or has just been restarted.

// File: rtl/drum_seq_pkg.sv
package drum_seq_pkg;
  typedef enum logic {
    MODE_EVENT = 1'b0,
    MODE_TIME  = 1'b1
  } mode_e;
endpackage

// File: rtl/drum_tick_gen.sv
module drum_tick_gen #(
  parameter int unsigned TICK_DIV = 20_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = $clog2(TICK_DIV + 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == CNT_W'(TICK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/drum_step_table.sv
module drum_step_table #(
  parameter int unsigned OUT_W     = 8,
  parameter int unsigned PRESET_W  = 8,
  parameter int unsigned MAX_STEPS = 100,
  parameter int unsigned IDX_W     = $clog2(MAX_STEPS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_addr_i,
  input  logic [OUT_W-1:0]    wr_pattern_i,
  input  logic [PRESET_W-1:0] wr_preset_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [OUT_W-1:0]    rd_pattern_o,
  output logic [PRESET_W-1:0] rd_preset_o
);
  logic [OUT_W-1:0]    pat_q [MAX_STEPS];
  logic [PRESET_W-1:0] pre_q [MAX_STEPS];

  // one register row per step; out-of-range addresses match no row
  for (genvar e = 0; e < MAX_STEPS; e++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pat_q[e] <= '0;
        pre_q[e] <= '0;
      end else if (wr_en_i && (32'(wr_addr_i) == e)) begin
        pat_q[e] <= wr_pattern_i;
        pre_q[e] <= wr_preset_i;
      end
    end
  end

  assign rd_pattern_o = pat_q[rd_idx_i];
  assign rd_preset_o  = pre_q[rd_idx_i];
endmodule

// File: rtl/drum_step_ctrl.sv
module drum_step_ctrl
  import drum_seq_pkg::*;
#(
  parameter int unsigned PRESET_W  = 8,
  parameter int unsigned MAX_STEPS = 100,
  parameter int unsigned IDX_W     = $clog2(MAX_STEPS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_i,
  input  logic                cond_i,
  input  logic                tick_i,
  input  logic                seq_rst_i,
  input  logic [IDX_W-1:0]    last_step_i,
  input  logic [PRESET_W-1:0] preset_i,
  output logic                cond_rise_o,
  output logic [IDX_W-1:0]    step_o,
  output logic [PRESET_W-1:0] acc_o
);
  localparam logic [IDX_W-1:0] LAST_MAX = IDX_W'(MAX_STEPS - 1);

  mode_e               mode;
  logic                cond_q;
  logic                inc;
  logic [PRESET_W:0]   acc_nxt;
  logic [PRESET_W:0]   eff_preset;
  logic [IDX_W-1:0]    last_eff;
  logic [IDX_W-1:0]    step_nxt;
  logic [IDX_W-1:0]    step_q;
  logic [PRESET_W-1:0] acc_q;

  assign mode        = mode_e'(mode_i);
  assign cond_rise_o = cond_i & ~cond_q;
  assign inc         = (mode == MODE_EVENT) ? cond_rise_o : (tick_i & cond_i);

  // zero preset counts as one so a step always takes at least one increment
  assign eff_preset = (preset_i == '0) ? (PRESET_W+1)'(1) : {1'b0, preset_i};
  assign acc_nxt    = {1'b0, acc_q} + 1'b1;

  assign last_eff = (32'(last_step_i) >= MAX_STEPS) ? LAST_MAX : last_step_i;
  assign step_nxt = (step_q >= last_eff) ? '0 : step_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= 1'b0;
    else         cond_q <= cond_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      acc_q  <= '0;
    end else if (seq_rst_i) begin
      step_q <= '0;
      acc_q  <= '0;
    end else if (inc) begin
      if (acc_nxt >= eff_preset) begin
        step_q <= step_nxt;
        acc_q  <= '0;
      end else begin
        acc_q  <= acc_nxt[PRESET_W-1:0];
      end
    end
  end

  assign step_o = step_q;
  assign acc_o  = acc_q;
endmodule

// File: rtl/drum_seq.sv
module drum_seq #(
  parameter int unsigned OUT_W     = 8,
  parameter int unsigned PRESET_W  = 8,
  parameter int unsigned MAX_STEPS = 100,
  parameter int unsigned TICK_DIV  = 20_000_000,
  localparam int unsigned IDX_W    = $clog2(MAX_STEPS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_i,
  input  logic                cond_i,
  input  logic                seq_rst_i,
  input  logic [IDX_W-1:0]    last_step_i,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_addr_i,
  input  logic [OUT_W-1:0]    wr_pattern_i,
  input  logic [PRESET_W-1:0] wr_preset_i,
  output logic [IDX_W-1:0]    step_o,
  output logic [PRESET_W-1:0] acc_o,
  output logic [OUT_W-1:0]    out_o
);
  logic                tick;
  logic                cond_rise;
  logic [IDX_W-1:0]    step;
  logic [PRESET_W-1:0] cur_preset;

  drum_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  drum_step_table #(
    .OUT_W(OUT_W), .PRESET_W(PRESET_W), .MAX_STEPS(MAX_STEPS), .IDX_W(IDX_W)
  ) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_pattern_i (wr_pattern_i),
    .wr_preset_i  (wr_preset_i),
    .rd_idx_i     (step),
    .rd_pattern_o (out_o),
    .rd_preset_o  (cur_preset)
  );

  drum_step_ctrl #(
    .PRESET_W(PRESET_W), .MAX_STEPS(MAX_STEPS), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .cond_i      (cond_i),
    .tick_i      (tick),
    .seq_rst_i   (seq_rst_i),
    .last_step_i (last_step_i),
    .preset_i    (cur_preset),
    .cond_rise_o (cond_rise),
    .step_o      (step),
    .acc_o       (acc_o)
  );

  assign step_o = step;
endmodule

// File: rtl/drum_seq_checker.sv
module drum_seq_checker #(
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned ACC_W     = 8,
  parameter int unsigned MAX_STEPS = 100
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             cond_i,
  input logic             seq_rst_i,
  input logic             rise_i,
  input logic [IDX_W-1:0] step_i,
  input logic [ACC_W-1:0] acc_i
);
  AST_STEP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(step_i) < MAX_STEPS); // R6

  AST_STEP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(step_i) |-> (step_i == '0 || step_i == $past(step_i) + 1'b1)); // R6

  AST_ACC_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acc_i) |-> (acc_i == '0 || acc_i == $past(acc_i) + 1'b1)); // R4

  AST_ADVANCE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(step_i) |-> acc_i == '0); // R4

  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_rst_i |=> (step_i == '0 && acc_i == '0)); // R7

  AST_EVENT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !rise_i && !seq_rst_i) |=> ($stable(acc_i) && $stable(step_i))); // R2

  AST_TIME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !cond_i && !seq_rst_i) |=> ($stable(acc_i) && $stable(step_i))); // R3
endmodule

bind drum_seq drum_seq_checker #(
  .IDX_W(IDX_W), .ACC_W(PRESET_W), .MAX_STEPS(MAX_STEPS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .cond_i    (cond_i),
  .seq_rst_i (seq_rst_i),
  .rise_i    (cond_rise),
  .step_i    (step_o),
  .acc_i     (acc_o)
);

// File: tb/drum_seq_bench.sv
module drum_seq_bench;
  localparam int TDIV = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b0;
  logic       cond_i = 1'b0;
  logic       seq_rst_i = 1'b0;
  logic [6:0] last_step_i = 7'd3;
  logic       wr_en_i = 1'b0;
  logic [6:0] wr_addr_i = '0;
  logic [7:0] wr_pattern_i = '0;
  logic [7:0] wr_preset_i = '0;
  logic [6:0] step_o;
  logic [7:0] acc_o;
  logic [7:0] out_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  drum_seq #(.TICK_DIV(TDIV)) u_drum_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .cond_i(cond_i),
    .seq_rst_i(seq_rst_i), .last_step_i(last_step_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_pattern_i(wr_pattern_i), .wr_preset_i(wr_preset_i),
    .step_o(step_o), .acc_o(acc_o), .out_o(out_o)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_state(string req, int s, int a, int o);
    chk({req, " step"}, int'(step_o), s);
    chk({req, " acc"},  int'(acc_o),  a);
    chk({req, " out"},  int'(out_o),  o);
  endtask

  task automatic wr_row(int addr, int pat, int pre);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 7'(addr); wr_pattern_i = 8'(pat); wr_preset_i = 8'(pre);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic cond_edge();
    @(negedge clk_i); cond_i = 1'b1;
    @(negedge clk_i); cond_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic restart();
    @(negedge clk_i); seq_rst_i = 1'b1;
    @(negedge clk_i); seq_rst_i = 1'b0;
  endtask

  task automatic t_reset();
    chk_state("R8 reset", 0, 0, 0);
  endtask

  task automatic t_event();
    wr_row(0, 8'h11, 3);
    wr_row(1, 8'h22, 0);
    wr_row(2, 8'h33, 2);
    wr_row(3, 8'h44, 1);
    chk("R9 R1 loaded row0 out", int'(out_o), 8'h11);
    cond_edge();
    chk_state("R2 first edge", 0, 1, 8'h11);
    @(negedge clk_i); cond_i = 1'b1;
    repeat (6) @(negedge clk_i);
    chk_state("R2 held high", 0, 2, 8'h11);
    cond_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk_state("R2 held low", 0, 2, 8'h11);
    cond_edge();
    chk_state("R4 R1 advance", 1, 0, 8'h22);
  endtask

  task automatic t_zero_and_wrap();
    cond_edge();
    chk_state("R5 zero preset", 2, 0, 8'h33);
    cond_edge();
    chk_state("R4 step2 count", 2, 1, 8'h33);
    cond_edge();
    chk_state("R4 step2 done", 3, 0, 8'h44);
    cond_edge();
    chk_state("R6 wrap", 0, 0, 8'h11);
  endtask

  task automatic t_restart();
    cond_edge();
    cond_edge();
    chk_state("R7 pre", 0, 2, 8'h11);
    @(negedge clk_i); cond_i = 1'b1; seq_rst_i = 1'b1;
    @(negedge clk_i); cond_i = 1'b0; seq_rst_i = 1'b0;
    chk_state("R7 override", 0, 0, 8'h11);
    cond_edge();
    restart();
    chk_state("R7 restart", 0, 0, 8'h11);
  endtask

  task automatic t_time();
    int waited = 0;
    wr_row(0, 8'h11, 5);
    restart();
    mode_i = 1'b1;
    @(negedge clk_i); cond_i = 1'b1;
    while (acc_o == 0 && waited < 4 * TDIV) begin
      @(negedge clk_i); waited++;
    end
    chk("R3 first tick", int'(acc_o), 1);
    repeat (TDIV - 1) @(negedge clk_i);
    chk("R3 between ticks", int'(acc_o), 1);
    @(negedge clk_i);
    chk("R3 next tick", int'(acc_o), 2);
    cond_i = 1'b0;
    repeat (3 * TDIV) @(negedge clk_i);
    chk_state("R3 cond low holds", 0, 2, 8'h11);
    cond_i = 1'b1;
    waited = 0;
    while (step_o == 0 && waited < 8 * TDIV) begin
      @(negedge clk_i); waited++;
    end
    cond_i = 1'b0;
    chk_state("R3 R4 timed advance", 1, 0, 8'h22);
    chk("R3 dwell length", waited, 3 * TDIV);
    mode_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_clamp();
    for (int i = 0; i < 100; i++) wr_row(i, i ^ 8'h5A, 1);
    last_step_i = 7'd127;
    restart();
    chk("R9 row0 reload", int'(out_o), 8'h5A);
    for (int i = 0; i < 99; i++) cond_edge();
    chk_state("R6 last row", 99, 0, 99 ^ 8'h5A);
    cond_edge();
    chk_state("R6 clamp wrap", 0, 0, 8'h5A);
    wr_row(100, 8'hFF, 9);
    wr_row(127, 8'hEE, 9);
    chk("R9 out of range ignored out", int'(out_o), 8'h5A);
    cond_edge();
    chk_state("R9 out of range preset kept", 1, 0, 1 ^ 8'h5A);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_event();
        t_zero_and_wrap();
        t_restart();
        t_time();
        t_clamp();
      end
      begin
        repeat (150_000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule